// File: doc/BRIEF.md
# Serial Data Carrier Modulator

This block is the output stage that drives a timer's output pin. It takes the timer's toggle flip-flop, a carrier from a duty-cycle generator, and the data and timing of a serial shift register. From these it builds one output line under a 3-bit output-mode code. The counters and the shift register sit outside the block. They reach it only as single-cycle strobes: compare matches and overflows for an 8-bit and a 12-bit counter arrangement, shift start and stop, a 4-bit stage match, bit-cell boundaries and half-cell ticks.

Software selects a coding scheme and, in the same write, can preset the flip-flop. The available schemes are plain toggling, carrier bursts gated by the flip-flop, carrier bursts gated by serial data, bi-phase, Manchester, direct serial data and a PWM that accepts only one compare match per period. Modulation runs from a shift start until a shift stop or a 4-bit stage match. The 4-bit match lets a message end partway through a byte. While modulation is idle, the pin shows the flip-flop.

Top module: `serial_carrier_mod`

## Requirements
- R1: The mode register resets to 111 and is loaded from `cfg_mode` on `cfg_wr`. In mode 111 the pin equals the flip-flop. Outside PWM mode the flip-flop toggles on a selected compare match when `cmp_tog_en`=1 and on a selected overflow when `ovf_tog_en`=1. If both act in the same cycle, it does not change.
- R2: A `cfg_wr` with `timer_run`=0 loads `cfg_preset` into the flip-flop on that edge. With `timer_run`=1 the preset is ignored.
- R3: In mode 001 (PWM) the pin equals the flip-flop. A selected overflow toggles it and re-arms. Only the first selected compare match after reset, a `cfg_wr` or an overflow toggles it, and later matches leave it unchanged. An overflow and a match in the same cycle give one toggle.
- R4: With `wide_sel`=1 only the 12-bit strobes (`cmp12_hit`, `ovf12_hit`) count. With `wide_sel`=0 only the 8-bit strobes count.
- R5: Modulation becomes active on the edge after `sr_start`. It becomes idle on the edge after `sr_stop` or `bitcnt_hit`. A stop wins over a start in the same cycle.
- R6: While idle, the pin equals the flip-flop in every mode.
- R7: While active, mode 110 drives `carrier` AND flip-flop, and mode 101 drives `carrier` AND `sr_data`.
- R8: In mode 100 (bi-phase) the pin follows a level register. An accepted start loads it with the inverse of the flip-flop. While active it toggles on `bit_tick`, and also on `half_tick` when `sr_data`=0.
- R9: In mode 011 (Manchester) the active pin is `sr_data` XOR a phase bit. The phase is cleared by an accepted start or by `bit_tick`, and set by `half_tick`. `bit_tick` wins.
- R10: In mode 010 the active pin equals `sr_data`.
- R11: After reset the flip-flop is 0, modulation is idle and the pin is 0.
- R12: Code 000 drives the flip-flop value to the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Mode register write strobe |
| cfg_mode | input | 3 | Output-mode code written |
| cfg_preset | input | 1 | Flip-flop preset value written |
| timer_run | input | 1 | Timer run state; blocks the preset |
| wide_sel | input | 1 | 1 selects the 12-bit counter strobes |
| cmp8_hit | input | 1 | 8-bit compare match strobe |
| ovf8_hit | input | 1 | 8-bit overflow strobe |
| cmp12_hit | input | 1 | 12-bit compare match strobe |
| ovf12_hit | input | 1 | 12-bit overflow strobe |
| cmp_tog_en | input | 1 | Compare match toggles flip-flop |
| ovf_tog_en | input | 1 | Overflow toggles flip-flop |
| carrier | input | 1 | Duty-cycle generator carrier |
| sr_start | input | 1 | Shift register start strobe |
| sr_stop | input | 1 | Shift register stop strobe |
| bitcnt_hit | input | 1 | 4-bit stage compare match (early stop) |
| sr_data | input | 1 | Serial data bit currently shifted out |
| bit_tick | input | 1 | Bit-cell boundary strobe |
| half_tick | input | 1 | Mid-cell strobe from the timer toggle |
| mod_out | output | 1 | Timer output pin |

## Verification
The assertions check, on every cycle, that the preset is blocked while the timer runs and loaded when it is stopped. They also check that PWM ignores a second compare match until an overflow, that start and stop reach the active state on the next edge with stop winning, and that the idle pin equals the flip-flop. They further check that the bi-phase pin changes at every bit boundary. Only the bench's scenarios can show the full coded waveforms. These include Manchester cells, carrier gating, selection of the 8-bit or 12-bit strobes and early stop inside a byte. The bench checks them against a behavioural model over long mixed stimulus.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    OM_RSVD   = 3'b000,
    OM_PWM    = 3'b001,
    OM_PASS   = 3'b010,
    OM_MANCH  = 3'b011,
    OM_BIPH   = 3'b100,
    OM_BURSTD = 3'b101,
    OM_BURSTF = 3'b110,
    OM_TOGGLE = 3'b111
  } out_mode_e;

  // pick the strobe of the counter arrangement in use
  function automatic logic pick_strobe(input logic wide, input logic s8, input logic s12);
    return wide ? s12 : s8;
  endfunction

  // carrier burst: carrier passes only while the gate is high
  function automatic logic burst_level(input logic carr, input logic gate);
    return carr & gate;
  endfunction

  // Manchester: data in first half-cell, complement in second
  function automatic logic manch_level(input logic d, input logic second_half);
    return d ^ second_half;
  endfunction
endpackage

// File: rtl/mcm_run_ctrl.sv
module mcm_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic sr_start,
  input  logic sr_stop,
  input  logic bitcnt_hit,
  output logic start_acc,
  output logic stop_evt,
  output logic active
);
  assign stop_evt  = sr_stop | bitcnt_hit;
  assign start_acc = sr_start & ~stop_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active <= 1'b0;
    else if (stop_evt)  active <= 1'b0;
    else if (sr_start)  active <= 1'b1;
  end

  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_stop || bitcnt_hit) |=> !active); // R5
  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_start && !sr_stop && !bitcnt_hit) |=> active); // R5
endmodule

// File: rtl/mcm_toggle_ff.sv
module mcm_toggle_ff
  import mcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  out_mode_e mode,
  input  logic      cfg_wr,
  input  logic      cfg_preset,
  input  logic      timer_run,
  input  logic      cmp_s,
  input  logic      ovf_s,
  input  logic      cmp_tog_en,
  input  logic      ovf_tog_en,
  output logic      ff_q
);
  logic armed_q;
  logic preset_ok;
  logic pwm_mode;
  logic pwm_flip;
  logic std_flip;
  logic flip;

  assign preset_ok = cfg_wr & ~timer_run;
  assign pwm_mode  = (mode == OM_PWM);
  assign pwm_flip  = ovf_s | (cmp_s & armed_q);
  assign std_flip  = (cmp_s & cmp_tog_en) ^ (ovf_s & ovf_tog_en);
  assign flip      = pwm_mode ? pwm_flip : std_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ff_q <= 1'b0;
    else if (preset_ok) ff_q <= cfg_preset;
    else if (flip)      ff_q <= ~ff_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed_q <= 1'b1;
    else if (cfg_wr)           armed_q <= 1'b1;
    else if (pwm_mode && ovf_s) armed_q <= 1'b1;
    else if (pwm_mode && cmp_s) armed_q <= 1'b0;
  end

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !timer_run) |=> (ff_q == $past(cfg_preset))); // R2
  AST_PRESET_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && timer_run && !cmp_s && !ovf_s) |=> $stable(ff_q)); // R2
  AST_PWM_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && cmp_s && !armed_q && !ovf_s && !preset_ok) |=> $stable(ff_q)); // R3
endmodule

// File: rtl/mcm_coder.sv
module mcm_coder
  import mcm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  out_mode_e mode,
  input  logic      cfg_wr,
  input  logic      active,
  input  logic      start_acc,
  input  logic      stop_evt,
  input  logic      ff_q,
  input  logic      carrier,
  input  logic      sr_data,
  input  logic      bit_tick,
  input  logic      half_tick,
  output logic      pin
);
  logic bp_q;
  logic ph_q;
  logic coded;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 bp_q <= 1'b0;
    else if (start_acc)                         bp_q <= ~ff_q;
    else if (active && bit_tick)                bp_q <= ~bp_q;
    else if (active && half_tick && !sr_data)   bp_q <= ~bp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ph_q <= 1'b0;
    else if (start_acc || bit_tick)  ph_q <= 1'b0;
    else if (half_tick)              ph_q <= 1'b1;
  end

  always_comb begin
    unique case (mode)
      OM_BURSTF: coded = burst_level(carrier, ff_q);
      OM_BURSTD: coded = burst_level(carrier, sr_data);
      OM_BIPH:   coded = bp_q;
      OM_MANCH:  coded = manch_level(sr_data, ph_q);
      OM_PASS:   coded = sr_data;
      default:   coded = ff_q;
    endcase
  end

  assign pin = active ? coded : ff_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pin == ff_q)); // R6
  AST_BIPHASE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && mode == OM_BIPH && bit_tick && !stop_evt && !start_acc && !cfg_wr)
      |=> (pin != $past(pin))); // R8
endmodule

// File: rtl/serial_carrier_mod.sv
module serial_carrier_mod
  import mcm_pkg::*;
#(
  parameter logic [MODE_W-1:0] RST_MODE = 3'b111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_preset,
  input  logic              timer_run,
  input  logic              wide_sel,
  input  logic              cmp8_hit,
  input  logic              ovf8_hit,
  input  logic              cmp12_hit,
  input  logic              ovf12_hit,
  input  logic              cmp_tog_en,
  input  logic              ovf_tog_en,
  input  logic              carrier,
  input  logic              sr_start,
  input  logic              sr_stop,
  input  logic              bitcnt_hit,
  input  logic              sr_data,
  input  logic              bit_tick,
  input  logic              half_tick,
  output logic              mod_out
);
  out_mode_e mode_q;
  logic cmp_s, ovf_s;
  logic start_acc, stop_evt, active;
  logic ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= out_mode_e'(RST_MODE);
    else if (cfg_wr) mode_q <= out_mode_e'(cfg_mode);
  end

  assign cmp_s = pick_strobe(wide_sel, cmp8_hit, cmp12_hit);
  assign ovf_s = pick_strobe(wide_sel, ovf8_hit, ovf12_hit);

  mcm_run_ctrl u_run (
    .clk(clk), .rst_n(rst_n), .sr_start(sr_start), .sr_stop(sr_stop),
    .bitcnt_hit(bitcnt_hit), .start_acc(start_acc), .stop_evt(stop_evt),
    .active(active)
  );

  mcm_toggle_ff u_ff (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .cfg_wr(cfg_wr),
    .cfg_preset(cfg_preset), .timer_run(timer_run), .cmp_s(cmp_s),
    .ovf_s(ovf_s), .cmp_tog_en(cmp_tog_en), .ovf_tog_en(ovf_tog_en),
    .ff_q(ff_q)
  );

  mcm_coder u_coder (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .cfg_wr(cfg_wr),
    .active(active), .start_acc(start_acc), .stop_evt(stop_evt),
    .ff_q(ff_q), .carrier(carrier), .sr_data(sr_data),
    .bit_tick(bit_tick), .half_tick(half_tick), .pin(mod_out)
  );

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (mode_q == $past(cfg_mode))); // R1
endmodule

// File: tb/serial_carrier_mod_bench.sv
module serial_carrier_mod_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 0, cfg_preset = 0, timer_run = 0, wide_sel = 0;
  logic [2:0] cfg_mode = 3'b111;
  logic cmp8_hit = 0, ovf8_hit = 0, cmp12_hit = 0, ovf12_hit = 0;
  logic cmp_tog_en = 0, ovf_tog_en = 0, carrier = 0;
  logic sr_start = 0, sr_stop = 0, bitcnt_hit = 0, sr_data = 0;
  logic bit_tick = 0, half_tick = 0;
  logic mod_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_carrier_mod u_serial_carrier_mod (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
    .cfg_preset(cfg_preset), .timer_run(timer_run), .wide_sel(wide_sel),
    .cmp8_hit(cmp8_hit), .ovf8_hit(ovf8_hit), .cmp12_hit(cmp12_hit),
    .ovf12_hit(ovf12_hit), .cmp_tog_en(cmp_tog_en), .ovf_tog_en(ovf_tog_en),
    .carrier(carrier), .sr_start(sr_start), .sr_stop(sr_stop),
    .bitcnt_hit(bitcnt_hit), .sr_data(sr_data), .bit_tick(bit_tick),
    .half_tick(half_tick), .mod_out(mod_out)
  );

  // behavioural reference model
  int  m_mode = 7;
  bit  m_ff = 0, m_armed = 1, m_act = 0, m_bp = 0, m_ph = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 7; m_ff = 0; m_armed = 1; m_act = 0; m_bp = 0; m_ph = 0;
    end else begin
      bit c, o, stp, nff, narm, nact, nbp, nph;
      c = wide_sel ? cmp12_hit : cmp8_hit;
      o = wide_sel ? ovf12_hit : ovf8_hit;
      stp = sr_stop | bitcnt_hit;
      nff = m_ff; narm = m_armed; nact = m_act; nbp = m_bp; nph = m_ph;
      if (cfg_wr && !timer_run) nff = cfg_preset;
      else if (m_mode == 1) begin
        if (o || (c && m_armed)) nff = !m_ff;
      end else begin
        int n;
        n = (c && cmp_tog_en) + (o && ovf_tog_en);
        if (n == 1) nff = !m_ff;
      end
      if (cfg_wr) narm = 1;
      else if (m_mode == 1 && o) narm = 1;
      else if (m_mode == 1 && c) narm = 0;
      if (stp) nact = 0; else if (sr_start) nact = 1;
      if (sr_start && !stp) nbp = !m_ff;
      else if (m_act && (bit_tick || (half_tick && !sr_data))) nbp = !m_bp;
      if ((sr_start && !stp) || bit_tick) nph = 0; else if (half_tick) nph = 1;
      if (cfg_wr) m_mode = cfg_mode;
      m_ff = nff; m_armed = narm; m_act = nact; m_bp = nbp; m_ph = nph;
    end
  end

  function automatic bit model_out();
    if (!m_act) return m_ff;
    case (m_mode)
      6: return carrier && m_ff;
      5: return carrier && sr_data;
      4: return m_bp;
      3: return sr_data != m_ph;
      2: return sr_data;
      default: return m_ff;
    endcase
  endfunction

  function automatic string req_of();
    if (!m_act) return "R6";
    case (m_mode)
      7: return "R1";
      6, 5: return "R7";
      4: return "R8";
      3: return "R9";
      2: return "R10";
      1: return "R3";
      default: return "R12";
    endcase
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (mod_out !== model_out()) begin
        errors++;
        $display("FAIL %s cycle compare: got %0b exp %0b (mode %0d)",
                 req_of(), mod_out, model_out(), m_mode);
      end
    end
  end

  task automatic expect_out(input bit exp, input string req);
    #1;
    checks++;
    if (mod_out !== exp) begin
      errors++;
      $display("FAIL %s directed: got %0b exp %0b", req, mod_out, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    cfg_wr = 0; cmp8_hit = 0; ovf8_hit = 0; cmp12_hit = 0; ovf12_hit = 0;
    sr_start = 0; sr_stop = 0; bitcnt_hit = 0; bit_tick = 0; half_tick = 0;
  endtask

  task automatic write_mode(input bit [2:0] m, input bit p);
    cfg_wr = 1; cfg_mode = m; cfg_preset = p; tick();
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    expect_out(1'b0, "R11");
    // R2: preset with timer stopped, then blocked while running
    write_mode(3'b111, 1'b1);      expect_out(1'b1, "R2");
    timer_run = 1; write_mode(3'b111, 1'b0); expect_out(1'b1, "R2");
    timer_run = 0;
    // R1: compare toggles, simultaneous compare+overflow cancel
    cmp_tog_en = 1; ovf_tog_en = 1;
    cmp8_hit = 1; tick();          expect_out(1'b0, "R1");
    cmp8_hit = 1; ovf8_hit = 1; tick(); expect_out(1'b0, "R1");
    // R4: 12-bit strobes only when wide
    wide_sel = 1;
    cmp8_hit = 1; tick();          expect_out(1'b0, "R4");
    cmp12_hit = 1; tick();         expect_out(1'b1, "R4");
    wide_sel = 0;
    // R3: PWM first match only
    write_mode(3'b001, 1'b0);
    cmp8_hit = 1; tick();          expect_out(1'b1, "R3");
    cmp8_hit = 1; tick();          expect_out(1'b1, "R3");
    ovf8_hit = 1; tick();          expect_out(1'b0, "R3");
    cmp8_hit = 1; tick();          expect_out(1'b1, "R3");
    // R12: reserved code
    write_mode(3'b000, 1'b0);      expect_out(1'b0, "R12");
    // R9: Manchester cell
    write_mode(3'b011, 1'b0);
    sr_start = 1; sr_data = 1; tick(); expect_out(1'b1, "R9");
    half_tick = 1; tick();         expect_out(1'b0, "R9");
    bit_tick = 1; sr_data = 0; tick(); expect_out(1'b0, "R9");
    // R5/R6: early stop by 4-bit match returns pin to flip-flop (0)
    half_tick = 1; tick();         expect_out(1'b1, "R9");
    bitcnt_hit = 1; tick();        expect_out(1'b0, "R5");
    // R5: stop beats start
    sr_start = 1; sr_stop = 1; sr_data = 1; tick(); expect_out(1'b0, "R5");
    // R10 pass-through
    write_mode(3'b010, 1'b0);
    sr_start = 1; tick(); sr_data = 1; expect_out(1'b1, "R10");
    sr_data = 0; expect_out(1'b0, "R10");
    // R7 burst gated by data
    write_mode(3'b101, 1'b0);
    carrier = 1; sr_data = 1;      expect_out(1'b1, "R7");
    carrier = 0;                   expect_out(1'b0, "R7");
    sr_stop = 1; tick();
    // mixed stimulus checked every cycle against the model
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) begin cfg_wr = 1; cfg_mode = 3'($urandom_range(0, 7)); cfg_preset = 1'($urandom); end
      timer_run  = ($urandom_range(0, 3) != 0);
      if ($urandom_range(0, 63) == 0) wide_sel = !wide_sel;
      cmp8_hit   = ($urandom_range(0, 5) == 0);
      ovf8_hit   = ($urandom_range(0, 9) == 0);
      cmp12_hit  = ($urandom_range(0, 5) == 0);
      ovf12_hit  = ($urandom_range(0, 9) == 0);
      cmp_tog_en = ($urandom_range(0, 3) != 0);
      ovf_tog_en = ($urandom_range(0, 2) == 0);
      carrier    = 1'($urandom);
      sr_start   = ($urandom_range(0, 19) == 0);
      sr_stop    = ($urandom_range(0, 39) == 0);
      bitcnt_hit = ($urandom_range(0, 59) == 0);
      r = $urandom_range(0, 7);
      bit_tick   = (r == 0);
      half_tick  = (r == 1 || r == 2);
      if (bit_tick || $urandom_range(0, 7) == 0) sr_data = 1'($urandom);
      tick();
    end
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule